// File: doc/BRIEF.md
# Receive Status Classifier

This block sits after a pair of 8b/10b decoders on the receive side of a serial link. Each cycle of the recovered parallel clock it takes two decoded characters, a low byte and a high byte. Each character comes with a control flag that marks a K character and a flag that says the 10-bit code was legal.

The block sorts the pair into one of several classes: idle, carrier extend, error propagation, ordinary data or invalid. From the class it forms a registered 16-bit data word and two status bits, `rx_dv` (data-valid) and `rx_er` (error).

A loss-of-signal input from the analog detector has priority over every class. While it is high, the block drives all eighteen outputs high. Downstream logic reads the two status bits as a code that names the class, and uses the data word as is.

Top module: `rx_status_classifier`

## Requirements
- R1: An idle pair gives rx_dv=0 and rx_er=0. An idle pair is a low byte 0xBC with the K flag set (K28.5), and a high byte 0xC5 (D5.6) or 0x50 (D16.2) with the K flag clear, both codes valid.
- R2: For an idle pair, rxd[7:0] is 0xBC and rxd[15:8] repeats the received high byte (0xC5 or 0x50).
- R3: A pair with both K flags clear and both codes valid is normal data: rx_dv=1, rx_er=0, and rxd is {high byte, low byte}.
- R4: A pair in which both bytes are 0xF7 with the K flag set (K23.7, carrier extend) gives rx_dv=0, rx_er=1 and rxd=0xF7F7.
- R5: A pair in which both bytes are 0xFE with the K flag set (K30.7, error propagation) gives rx_dv=1, rx_er=1 and rxd=0xFEFE.
- R6: If either code-valid flag is low, the output is rx_dv=1, rx_er=1 and rxd=0x0000, whatever the bytes and K flags are.
- R7: Any other pair containing a K character gives rx_dv=1, rx_er=1 and rxd=0x0000. This covers mixed K codes, K28.5 followed by a high byte that is not an idle tail, and a K character on the high byte only.
- R8: While los=1, rx_dv, rx_er and all 16 bits of rxd are 1, whatever the character inputs are.
- R9: The outputs are registered. Inputs sampled at one rising clock edge appear on the outputs just after that edge, and the outputs hold until the next edge.
- R10: While rst_n is low, rxd, rx_dv and rx_er are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered parallel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lo_byte | input | 8 | Decoded low character |
| lo_is_k | input | 1 | Low character is a K character |
| lo_ok | input | 1 | Low character came from a valid 10-bit code |
| hi_byte | input | 8 | Decoded high character |
| hi_is_k | input | 1 | High character is a K character |
| hi_ok | input | 1 | High character came from a valid 10-bit code |
| los | input | 1 | Loss of signal, overrides everything |
| rxd | output | 16 | Registered data word |
| rx_dv | output | 1 | Data-valid status bit |
| rx_er | output | 1 | Error status bit |

## Verification
The block holds no state beyond its output register. A wrong classification therefore shows up at the ports on the first edge after the offending pair, as a wrong status code or a wrong data word. It does not linger into later cycles.

The checks that matter most are the near-miss pairs:
- K28.5 followed by a data byte that is not an idle tail.
- K28.5 followed by a K character.
- A single K23.7 or K30.7.
- A bad code hidden under an otherwise idle pair.

A confusion between classes is exposed on one cycle by these pairs. Each one is compared against the full 18-bit output one cycle after it is driven.

// File: rtl/rx_status_pkg.sv
// Package: shared widths, character codes and classification types for the
// receive status classifier. Assumes standard 8b/10b byte values.
package rx_status_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = BYTE_W * LANES;

    localparam logic [BYTE_W-1:0] CODE_COMMA  = 8'hBC; // K28.5
    localparam logic [BYTE_W-1:0] CODE_EXTEND = 8'hF7; // K23.7
    localparam logic [BYTE_W-1:0] CODE_PROP   = 8'hFE; // K30.7
    localparam logic [BYTE_W-1:0] CODE_TAIL_A = 8'hC5; // D5.6
    localparam logic [BYTE_W-1:0] CODE_TAIL_B = 8'h50; // D16.2

    typedef enum logic [2:0] {
        CH_DATA,
        CH_COMMA,
        CH_EXTEND,
        CH_PROPAGATE,
        CH_OTHER_K,
        CH_BAD
    } char_kind_t;

    typedef struct packed {
        char_kind_t kind;
        logic       idle_tail;
    } char_info_t;

    typedef enum logic [2:0] {
        PR_IDLE,
        PR_EXTEND,
        PR_DATA,
        PR_PROPAGATE,
        PR_INVALID
    } pair_class_t;
endpackage

// File: rtl/rx_char_id.sv
// Module: identifies a single decoded character.
// It reports whether the character is data, one of the three recognised
// K codes, some other K code, or an invalid code. It also flags the data
// bytes that may follow a comma in an idle pair.
// Assumes the decoder flags are valid in the same cycle as the byte.
module rx_char_id
    import rx_status_pkg::*;
(
    input  logic [BYTE_W-1:0] char_byte,
    input  logic              char_is_k,
    input  logic              char_ok,
    output char_info_t        info
);
    // Sort the character into its kind; a bad code wins over everything.
    always_comb begin
        info.idle_tail = 1'b0;
        if (!char_ok) begin
            info.kind = CH_BAD;
        end else if (!char_is_k) begin
            info.kind      = CH_DATA;
            info.idle_tail = (char_byte == CODE_TAIL_A) || (char_byte == CODE_TAIL_B);
        end else begin
            unique case (char_byte)
                CODE_COMMA:  info.kind = CH_COMMA;
                CODE_EXTEND: info.kind = CH_EXTEND;
                CODE_PROP:   info.kind = CH_PROPAGATE;
                default:     info.kind = CH_OTHER_K;
            endcase
        end
    end
endmodule

// File: rtl/rx_pair_map.sv
// Module: combines the two character descriptions into a pair class.
// It then maps the class to the next data word and the two status bits.
// Purely combinational; the caller registers the result.
module rx_pair_map
    import rx_status_pkg::*;
(
    input  char_info_t               lo_info,
    input  char_info_t               hi_info,
    input  logic [BYTE_W-1:0]        lo_byte,
    input  logic [BYTE_W-1:0]        hi_byte,
    output pair_class_t              pair_class,
    output logic [WORD_W-1:0]        next_data,
    output logic                     next_dv,
    output logic                     next_er
);
    // Decide the pair class; invalid codes take priority.
    always_comb begin
        if (lo_info.kind == CH_BAD || hi_info.kind == CH_BAD)
            pair_class = PR_INVALID;
        else if (lo_info.kind == CH_COMMA && hi_info.kind == CH_DATA && hi_info.idle_tail)
            pair_class = PR_IDLE;
        else if (lo_info.kind == CH_EXTEND && hi_info.kind == CH_EXTEND)
            pair_class = PR_EXTEND;
        else if (lo_info.kind == CH_PROPAGATE && hi_info.kind == CH_PROPAGATE)
            pair_class = PR_PROPAGATE;
        else if (lo_info.kind == CH_DATA && hi_info.kind == CH_DATA)
            pair_class = PR_DATA;
        else
            pair_class = PR_INVALID;
    end

    // Map the class to a status code and an output word.
    always_comb begin
        unique case (pair_class)
            PR_IDLE: begin
                next_dv   = 1'b0;
                next_er   = 1'b0;
                next_data = {hi_byte, CODE_COMMA};
            end
            PR_EXTEND: begin
                next_dv   = 1'b0;
                next_er   = 1'b1;
                next_data = {CODE_EXTEND, CODE_EXTEND};
            end
            PR_DATA: begin
                next_dv   = 1'b1;
                next_er   = 1'b0;
                next_data = {hi_byte, lo_byte};
            end
            PR_PROPAGATE: begin
                next_dv   = 1'b1;
                next_er   = 1'b1;
                next_data = {CODE_PROP, CODE_PROP};
            end
            default: begin
                next_dv   = 1'b1;
                next_er   = 1'b1;
                next_data = '0;
            end
        endcase
    end
endmodule

// File: rtl/rx_status_classifier.sv
// Module: top of the receive status classifier.
// It identifies both decoded characters, classifies the pair and registers
// the data word and status bits. Loss of signal forces all outputs high.
// Assumes the inputs are synchronous to clk; the reset is synchronous and
// active low.
module rx_status_classifier
    import rx_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        lo_byte,
    input  logic              lo_is_k,
    input  logic              lo_ok,
    input  logic [7:0]        hi_byte,
    input  logic              hi_is_k,
    input  logic              hi_ok,
    input  logic              los,
    output logic [15:0]       rxd,
    output logic              rx_dv,
    output logic              rx_er
);
    logic [LANES-1:0][BYTE_W-1:0] lane_byte;
    logic [LANES-1:0]             lane_k;
    logic [LANES-1:0]             lane_ok;
    char_info_t                   lane_info [LANES];

    pair_class_t                  pair_class;
    logic [WORD_W-1:0]            next_data;
    logic                         next_dv;
    logic                         next_er;

    // Gather the two characters into lane arrays, low byte in lane 0.
    always_comb begin
        lane_byte[0] = lo_byte;
        lane_byte[1] = hi_byte;
        lane_k       = {hi_is_k, lo_is_k};
        lane_ok      = {hi_ok, lo_ok};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rx_char_id u_id (
            .char_byte (lane_byte[g]),
            .char_is_k (lane_k[g]),
            .char_ok   (lane_ok[g]),
            .info      (lane_info[g])
        );
    end

    rx_pair_map u_map (
        .lo_info    (lane_info[0]),
        .hi_info    (lane_info[1]),
        .lo_byte    (lane_byte[0]),
        .hi_byte    (lane_byte[1]),
        .pair_class (pair_class),
        .next_data  (next_data),
        .next_dv    (next_dv),
        .next_er    (next_er)
    );

    // Output register with reset clear and loss-of-signal override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd   <= '0;
            rx_dv <= 1'b0;
            rx_er <= 1'b0;
        end else if (los) begin
            rxd   <= '1;
            rx_dv <= 1'b1;
            rx_er <= 1'b1;
        end else begin
            rxd   <= next_data;
            rx_dv <= next_dv;
            rx_er <= next_er;
        end
    end
endmodule

// File: rtl/rx_status_classifier_chk.sv
// Checker: port-level properties for rx_status_classifier, bound below.
// Each property relates the inputs at one edge to the outputs after it.
module rx_status_classifier_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  lo_byte,
    input logic        lo_is_k,
    input logic        lo_ok,
    input logic [7:0]  hi_byte,
    input logic        hi_is_k,
    input logic        hi_ok,
    input logic        los,
    input logic [15:0] rxd,
    input logic        rx_dv,
    input logic        rx_er
);
    // R8: loss of signal drives every output high.
    a_r8_los_all_high: assert property (@(posedge clk) disable iff (!rst_n)
        los |=> (rx_dv && rx_er && rxd == 16'hFFFF));

    // R1 and R2: an idle pair gives status 00 and the comma in the low byte.
    a_r1_idle_status: assert property (@(posedge clk) disable iff (!rst_n)
        (!los && lo_ok && hi_ok && lo_is_k && !hi_is_k && lo_byte == 8'hBC
         && (hi_byte == 8'hC5 || hi_byte == 8'h50))
        |=> (!rx_dv && !rx_er && rxd[7:0] == 8'hBC && rxd[15:8] == $past(hi_byte)));

    // R4: a carrier-extend pair gives status 01 and 0xF7F7.
    a_r4_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (!los && lo_ok && hi_ok && lo_is_k && hi_is_k && lo_byte == 8'hF7 && hi_byte == 8'hF7)
        |=> (!rx_dv && rx_er && rxd == 16'hF7F7));

    // R5: an error-propagation pair gives status 11 and 0xFEFE.
    a_r5_propagate: assert property (@(posedge clk) disable iff (!rst_n)
        (!los && lo_ok && hi_ok && lo_is_k && hi_is_k && lo_byte == 8'hFE && hi_byte == 8'hFE)
        |=> (rx_dv && rx_er && rxd == 16'hFEFE));

    // R3: plain data passes straight through with status 10.
    a_r3_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!los && lo_ok && hi_ok && !lo_is_k && !hi_is_k)
        |=> (rx_dv && !rx_er && rxd == {$past(hi_byte), $past(lo_byte)}));

    // R6: any bad code gives status 11 and a zero word.
    a_r6_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        (!los && (!lo_ok || !hi_ok)) |=> (rx_dv && rx_er && rxd == 16'h0000));
endmodule

bind rx_status_classifier rx_status_classifier_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_byte (lo_byte),
    .lo_is_k (lo_is_k),
    .lo_ok   (lo_ok),
    .hi_byte (hi_byte),
    .hi_is_k (hi_is_k),
    .hi_ok   (hi_ok),
    .los     (los),
    .rxd     (rxd),
    .rx_dv   (rx_dv),
    .rx_er   (rx_er)
);

// File: tb/sim_rx_status_classifier.sv
`timescale 1ns/1ps
// Directed bench for rx_status_classifier: one task per scenario.
module sim_rx_status_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  lo_byte = '0;
    logic        lo_is_k = 1'b0;
    logic        lo_ok = 1'b1;
    logic [7:0]  hi_byte = '0;
    logic        hi_is_k = 1'b0;
    logic        hi_ok = 1'b1;
    logic        los = 1'b0;
    logic [15:0] rxd;
    logic        rx_dv;
    logic        rx_er;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rx_status_classifier u0 (
        .clk(clk), .rst_n(rst_n),
        .lo_byte(lo_byte), .lo_is_k(lo_is_k), .lo_ok(lo_ok),
        .hi_byte(hi_byte), .hi_is_k(hi_is_k), .hi_ok(hi_ok),
        .los(los), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er)
    );

    // Compare {dv, er, rxd} against the expected value.
    task automatic check(input string req, input logic [17:0] exp);
        logic [17:0] act;
        act = {rx_dv, rx_er, rxd};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got dv=%b er=%b rxd=%h, want dv=%b er=%b rxd=%h",
                     req, act[17], act[16], act[15:0], exp[17], exp[16], exp[15:0]);
        end
    endtask

    // Drive one pair at the falling edge, then sample just after the rising edge.
    task automatic apply(input logic [7:0] lb, input logic lk, input logic lv,
                         input logic [7:0] hb, input logic hk, input logic hv,
                         input logic l);
        @(negedge clk);
        lo_byte = lb; lo_is_k = lk; lo_ok = lv;
        hi_byte = hb; hi_is_k = hk; hi_ok = hv; los = l;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        apply(8'h12, 0, 1, 8'h34, 0, 1, 1'b1);
        check("R10 reset with los high", 18'h0_0000);
        apply(8'hFE, 1, 1, 8'hFE, 1, 1, 1'b0);
        check("R10 reset with propagate pair", 18'h0_0000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        apply(8'hBC, 1, 1, 8'hC5, 0, 1, 0);
        check("R1 R2 idle D5.6", {2'b00, 16'hC5BC});
        apply(8'hBC, 1, 1, 8'h50, 0, 1, 0);
        check("R1 R2 idle D16.2", {2'b00, 16'h50BC});
    endtask

    task automatic t_data();
        apply(8'h12, 0, 1, 8'hA7, 0, 1, 0);
        check("R3 data pass", {2'b10, 16'hA712});
        apply(8'hBC, 0, 1, 8'hC5, 0, 1, 0);
        check("R3 data bytes that look idle", {2'b10, 16'hC5BC});
        apply(8'hFE, 0, 1, 8'hFE, 0, 1, 0);
        check("R3 data bytes that look propagate", {2'b10, 16'hFEFE});
    endtask

    task automatic t_extend();
        apply(8'hF7, 1, 1, 8'hF7, 1, 1, 0);
        check("R4 carrier extend", {2'b01, 16'hF7F7});
    endtask

    task automatic t_propagate();
        apply(8'hFE, 1, 1, 8'hFE, 1, 1, 0);
        check("R5 error propagation", {2'b11, 16'hFEFE});
    endtask

    task automatic t_bad();
        apply(8'hBC, 1, 0, 8'hC5, 0, 1, 0);
        check("R6 bad low code under idle", {2'b11, 16'h0000});
        apply(8'h12, 0, 1, 8'h34, 0, 0, 0);
        check("R6 bad high code", {2'b11, 16'h0000});
        apply(8'hFE, 1, 0, 8'hFE, 1, 0, 0);
        check("R6 both codes bad", {2'b11, 16'h0000});
    endtask

    task automatic t_other_k();
        apply(8'hBC, 1, 1, 8'h44, 0, 1, 0);
        check("R7 comma with non-idle tail", {2'b11, 16'h0000});
        apply(8'hBC, 1, 1, 8'hC5, 1, 1, 0);
        check("R7 comma with K tail", {2'b11, 16'h0000});
        apply(8'hF7, 1, 1, 8'hFE, 1, 1, 0);
        check("R7 mixed extend/propagate", {2'b11, 16'h0000});
        apply(8'h12, 0, 1, 8'hF7, 1, 1, 0);
        check("R7 K on high byte only", {2'b11, 16'h0000});
        apply(8'hF7, 1, 1, 8'hF7, 0, 1, 0);
        check("R7 single extend", {2'b11, 16'h0000});
    endtask

    task automatic t_los();
        apply(8'h12, 0, 1, 8'h34, 0, 1, 1);
        check("R8 los over data", {2'b11, 16'hFFFF});
        apply(8'hBC, 1, 1, 8'hC5, 0, 1, 1);
        check("R8 los over idle", {2'b11, 16'hFFFF});
        apply(8'h56, 0, 1, 8'h78, 0, 1, 0);
        check("R8 release of los", {2'b10, 16'h7856});
    endtask

    task automatic t_latency();
        apply(8'h9A, 0, 1, 8'hBD, 0, 1, 0);
        check("R9 first value", {2'b10, 16'hBD9A});
        @(negedge clk);
        lo_byte = 8'hF7; lo_is_k = 1; hi_byte = 8'hF7; hi_is_k = 1;
        #1;
        check("R9 hold before edge", {2'b10, 16'hBD9A});
        @(posedge clk);
        #1;
        check("R9 update after edge", {2'b01, 16'hF7F7});
    endtask

    initial begin
        t_reset();
        t_idle();
        t_data();
        t_extend();
        t_propagate();
        t_bad();
        t_other_k();
        t_los();
        t_latency();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule